// File: doc/BRIEF.md
# Interrupt Enable and Pending Qualifier

This block decides, every clock, whether the core should take a hardware interrupt. It holds two small control registers. The control word has a global enable bit, an exception-level bit, an error-level bit and an 8-bit mask field. The cause word has an 8-bit pending field. Both are loaded through one register-write port. Six of the pending bits follow the hardware interrupt lines and two are set by software. Three external conditions also gate the result: the core is in debug mode, the running thread is marked exempt from interrupts, and a configuration bit selects an external vectoring controller.

The mask field has two readings. In compatibility mode each mask bit enables the pending line at the same position. In external-vector mode the pending field is an unsigned priority number and the mask field is a level. An interrupt is pending only when the number is strictly above the level. The block reports whether interrupts are enabled and whether one is pending. It also gives a registered take signal for the exception sequencer, which is not part of this block.

Top module: `irq_gate_eval`

## Requirements
- R1: `irq_enabled` is high only when control bit 0 (enable) is 1, control bit 1 (exception level) is 0 and control bit 2 (error level) is 0; the control word is written with `wr_sel`=0, and bits 2:0 and 15:8 of `wr_data` are kept.
- R2: While `dbg_mode` is high, `irq_enabled` is low.
- R3: While `thread_exempt` is high, `irq_enabled` is low.
- R4: With `ext_vec_mode` low, `irq_pending` is high when any bit of the pending field is set at the same position as a set bit of the mask field.
- R5: With `ext_vec_mode` high, `irq_pending` is high exactly when the pending field, read as an unsigned number, is strictly greater than the mask field, read as an unsigned level. An equal value is not pending.
- R6: `wr_data` bits outside 2:0 and 15:8 of a control write, and outside 9:8 of a cause write, have no effect on `irq_enabled` or `irq_pending`.
- R7: Pending bits 1:0 are written from `wr_data[9:8]` when `wr_sel`=1 and hold otherwise. Pending bits 7:2 are loaded from `hw_irq[5:0]` at every clock edge, and write data at those positions is ignored.
- R8: After reset the error-level bit is set, enable is clear, the mask and pending fields are zero, and `irq_enabled`, `irq_pending` and `take_irq` are low.
- R9: `take_irq` equals `irq_enabled` AND `irq_pending` as they stood before the previous clock edge. This gives one cycle of latency after a control change, a `dbg_mode`, `thread_exempt` or `ext_vec_mode` change, or a write. A change on `hw_irq` first passes through the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 cause word |
| wr_data | input | 32 | Write data |
| hw_irq | input | 6 | Hardware interrupt lines, loaded into pending bits 7:2 |
| dbg_mode | input | 1 | Core is in debug mode |
| thread_exempt | input | 1 | Active thread is exempt from interrupts |
| ext_vec_mode | input | 1 | External vectoring controller configured (level compare) |
| irq_enabled | output | 1 | Interrupts are enabled by the current state |
| irq_pending | output | 1 | An unmasked interrupt is pending |
| take_irq | output | 1 | Registered decision to take an interrupt |

## Verification
The hardest case is the boundary of the level compare. The pending number is built from two sources: software sets its two low bits and the hardware lines set the upper six. To place it exactly at, one above and one below the mask level, the bench drives a hardware line and a software write together. It checks both the strict inequality and the all-ones case where the number equals the level. The bench also shows the one-cycle gap between the combinational outputs and `take_irq`. It samples just after a `dbg_mode` change, while the take signal still shows the previous state.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  parameter int unsigned IRQ_REG_W     = 32;
  parameter int unsigned IRQ_FIELD_LSB = 8;
  parameter int unsigned IRQ_FIELD_W   = 8;
  parameter int unsigned IRQ_SW_W      = 2;

  // control-word bit positions (low bits of the control word)
  localparam int unsigned CTL_IE  = 0;
  localparam int unsigned CTL_EXL = 1;
  localparam int unsigned CTL_ERL = 2;
  localparam int unsigned CTL_W   = 3;

  typedef enum logic {
    TGT_CONTROL = 1'b0,
    TGT_CAUSE   = 1'b1
  } irq_wr_tgt_e;

  // control bits after reset: only the error level is set
  localparam logic [CTL_W-1:0] CTL_RESET = CTL_W'(1) << CTL_ERL;
endpackage

// File: rtl/irq_csr_store.sv
module irq_csr_store
  import irq_gate_pkg::*;
#(
  parameter int unsigned REG_W     = IRQ_REG_W,
  parameter int unsigned FIELD_LSB = IRQ_FIELD_LSB,
  parameter int unsigned FIELD_W   = IRQ_FIELD_W,
  parameter int unsigned SW_W      = IRQ_SW_W,
  localparam int unsigned HW_W     = FIELD_W - SW_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  irq_wr_tgt_e        wr_tgt,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [HW_W-1:0]    hw_irq,
  output logic [CTL_W-1:0]   ctl_q,
  output logic [FIELD_W-1:0] mask_q,
  output logic [FIELD_W-1:0] pend_q
);
  logic ctl_wr;
  logic cause_wr;
  logic [FIELD_W-1:0] wr_field;
  logic unused_wr_bits;

  assign ctl_wr   = wr_en && (wr_tgt == TGT_CONTROL);
  assign cause_wr = wr_en && (wr_tgt == TGT_CAUSE);
  assign wr_field = wr_data[FIELD_LSB +: FIELD_W];
  assign unused_wr_bits = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= CTL_RESET;
      mask_q <= '0;
    end else if (ctl_wr) begin
      ctl_q  <= wr_data[CTL_W-1:0];
      mask_q <= wr_field;
    end
  end

  for (genvar b = 0; b < FIELD_W; b++) begin : g_pend
    if (b < SW_W) begin : g_sw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pend_q[b] <= 1'b0;
        else if (cause_wr) pend_q[b] <= wr_field[b];
      end
    end else begin : g_hw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q[b] <= 1'b0;
        else        pend_q[b] <= hw_irq[b-SW_W];
      end
    end
  end

  // R7: upper pending bits track the hardware lines, writes notwithstanding
  assert_hw_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pend_q[FIELD_W-1:SW_W] == $past(hw_irq));
  // R7: software bits hold without a cause write
  assert_sw_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_wr |=> $stable(pend_q[SW_W-1:0]));
endmodule

// File: rtl/irq_enable_chk.sv
module irq_enable_chk
  import irq_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] ctl_q,
  input  logic             dbg_mode,
  input  logic             thread_exempt,
  output logic             enabled
);
  function automatic logic ctl_allows(input logic [CTL_W-1:0] c);
    return c[CTL_IE] && !c[CTL_EXL] && !c[CTL_ERL];
  endfunction

  logic blocked_ext;
  assign blocked_ext = dbg_mode || thread_exempt;
  assign enabled     = ctl_allows(ctl_q) && !blocked_ext;

  assert_level_block_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[CTL_EXL] || ctl_q[CTL_ERL] || !ctl_q[CTL_IE]) |-> !enabled);
  assert_debug_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mode |-> !enabled);
  assert_exempt_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    thread_exempt |-> !enabled);
endmodule

// File: rtl/irq_pend_cmp.sv
module irq_pend_cmp #(
  parameter int unsigned FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] pend_f,
  input  logic [FIELD_W-1:0] mask_f,
  input  logic               ext_vec_mode,
  output logic               pending
);
  function automatic logic per_line_hit(input logic [FIELD_W-1:0] p,
                                        input logic [FIELD_W-1:0] m);
    return |(p & m);
  endfunction

  function automatic logic level_above(input logic [FIELD_W-1:0] p,
                                       input logic [FIELD_W-1:0] m);
    return p > m;
  endfunction

  logic hit_lines;
  logic hit_level;
  assign hit_lines = per_line_hit(pend_f, mask_f);
  assign hit_level = level_above(pend_f, mask_f);
  assign pending   = ext_vec_mode ? hit_level : hit_lines;

  assert_empty_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_vec_mode && mask_f == '0) |-> !pending);
  assert_zero_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_vec_mode && pend_f == '0) |-> !pending);
  assert_top_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_vec_mode && mask_f == '1) |-> !pending);
endmodule

// File: rtl/irq_gate_eval.sv
module irq_gate_eval
  import irq_gate_pkg::*;
#(
  parameter int unsigned REG_W     = IRQ_REG_W,
  parameter int unsigned FIELD_LSB = IRQ_FIELD_LSB,
  parameter int unsigned FIELD_W   = IRQ_FIELD_W,
  parameter int unsigned SW_W      = IRQ_SW_W,
  localparam int unsigned HW_W     = FIELD_W - SW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [HW_W-1:0]  hw_irq,
  input  logic             dbg_mode,
  input  logic             thread_exempt,
  input  logic             ext_vec_mode,
  output logic             irq_enabled,
  output logic             irq_pending,
  output logic             take_irq
);
  logic [CTL_W-1:0]   ctl_q;
  logic [FIELD_W-1:0] mask_q;
  logic [FIELD_W-1:0] pend_q;
  logic               take_d;

  irq_csr_store #(
    .REG_W(REG_W), .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W), .SW_W(SW_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_tgt(irq_wr_tgt_e'(wr_sel)), .wr_data(wr_data), .hw_irq(hw_irq),
    .ctl_q(ctl_q), .mask_q(mask_q), .pend_q(pend_q)
  );

  irq_enable_chk u_enable (
    .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .dbg_mode(dbg_mode),
    .thread_exempt(thread_exempt), .enabled(irq_enabled)
  );

  irq_pend_cmp #(.FIELD_W(FIELD_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .pend_f(pend_q), .mask_f(mask_q),
    .ext_vec_mode(ext_vec_mode), .pending(irq_pending)
  );

  assign take_d = irq_enabled && irq_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) take_irq <= 1'b0;
    else        take_irq <= take_d;
  end

  // R9: a take is only raised on the cycle after both qualifiers held
  assert_take_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> $past(irq_enabled && irq_pending));
  // R8/R1: the error level from reset keeps the block silent
  assert_erl_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[CTL_ERL] |=> !take_irq);
endmodule

// File: tb/test_irq_gate_eval.sv
module test_irq_gate_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [5:0]  hw_irq = '0;
  logic        dbg_mode = 1'b0;
  logic        thread_exempt = 1'b0;
  logic        ext_vec_mode = 1'b0;
  logic        irq_enabled, irq_pending, take_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model of the architectural state
  logic [2:0] m_ctl   = 3'b100;
  logic [7:0] m_mask  = 8'h00;
  logic [7:0] m_cause = 8'h00;

  always #10 clk = ~clk;

  irq_gate_eval i_irq_gate_eval (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .hw_irq(hw_irq), .dbg_mode(dbg_mode),
    .thread_exempt(thread_exempt), .ext_vec_mode(ext_vec_mode),
    .irq_enabled(irq_enabled), .irq_pending(irq_pending), .take_irq(take_irq)
  );

  function automatic bit m_en(input bit dbg, input bit ex);
    // enable=bit0 set, exception level bit1 and error level bit2 clear
    return (m_ctl == 3'b001) && !dbg && !ex;
  endfunction

  function automatic bit m_pend(input bit ext);
    bit any = 0;
    if (ext) return int'(m_cause) > int'(m_mask);
    for (int i = 0; i < 8; i++) if (m_cause[i] && m_mask[i]) any = 1;
    return any;
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // called at a negedge; drives, lets one edge pass, checks at the next negedge
  task automatic step(input bit we, input bit sel, input logic [31:0] d,
                      input logic [5:0] hw, input bit dbg, input bit ex,
                      input bit ext, input string tag);
    bit exp_take;
    wr_en = we; wr_sel = sel; wr_data = d; hw_irq = hw;
    dbg_mode = dbg; thread_exempt = ex; ext_vec_mode = ext;
    exp_take = m_en(dbg, ex) && m_pend(ext);
    @(posedge clk);
    if (we && !sel) begin m_ctl = d[2:0]; m_mask = d[15:8]; end
    if (we && sel) m_cause[1:0] = d[9:8];
    m_cause[7:2] = hw;
    @(negedge clk);
    wr_en = 1'b0;
    check(tag, "irq_enabled", irq_enabled, m_en(dbg, ex));
    check(tag, "irq_pending", irq_pending, m_pend(ext));
    check(tag, "take_irq", take_irq, exp_take);
  endtask

  task automatic t_reset; // R8
    check("R8", "irq_enabled", irq_enabled, 1'b0);
    check("R8", "irq_pending", irq_pending, 1'b0);
    check("R8", "take_irq", take_irq, 1'b0);
    step(1, 1, 32'h0000_0300, 6'h00, 0, 0, 0, "R8");
    step(1, 0, 32'h0000_FF04, 6'h00, 0, 0, 0, "R8");
    check("R8", "error level holds off enable", irq_enabled, 1'b0);
    step(0, 0, 32'h0, 6'h00, 0, 0, 0, "R8");
  endtask

  task automatic t_enable_bits; // R1
    step(1, 0, 32'h0000_FF01, 6'h00, 0, 0, 0, "R1");
    step(0, 0, 32'h0, 6'h00, 0, 0, 0, "R1");
    step(1, 0, 32'h0000_FF03, 6'h00, 0, 0, 0, "R1");
    step(1, 0, 32'h0000_FF05, 6'h00, 0, 0, 0, "R1");
    step(1, 0, 32'h0000_FF00, 6'h00, 0, 0, 0, "R1");
    step(1, 0, 32'h0000_FF01, 6'h00, 0, 0, 0, "R1");
  endtask

  task automatic t_debug; // R2
    step(0, 0, 32'h0, 6'h00, 1, 0, 0, "R2");
    step(0, 0, 32'h0, 6'h00, 1, 0, 0, "R2");
    step(0, 0, 32'h0, 6'h00, 0, 0, 0, "R2");
  endtask

  task automatic t_exempt; // R3
    step(0, 0, 32'h0, 6'h00, 0, 1, 0, "R3");
    step(0, 0, 32'h0, 6'h00, 0, 1, 0, "R3");
    step(0, 0, 32'h0, 6'h00, 0, 0, 0, "R3");
  endtask

  task automatic t_compat; // R4
    step(1, 0, 32'h0000_0101, 6'h00, 0, 0, 0, "R4");
    step(1, 1, 32'h0000_0200, 6'h00, 0, 0, 0, "R4");
    step(1, 1, 32'h0000_0100, 6'h00, 0, 0, 0, "R4");
    step(1, 1, 32'h0000_0000, 6'h20, 0, 0, 0, "R4");
    step(1, 0, 32'h0000_8001, 6'h20, 0, 0, 0, "R4");
    step(0, 0, 32'h0, 6'h1F, 0, 0, 0, "R4");
  endtask

  task automatic t_extvec; // R5
    step(1, 0, 32'h0000_0501, 6'h00, 0, 0, 1, "R5");
    step(1, 1, 32'h0000_0100, 6'h01, 0, 0, 1, "R5"); // 5 vs 5
    step(1, 1, 32'h0000_0200, 6'h01, 0, 0, 1, "R5"); // 6 vs 5
    step(1, 1, 32'h0000_0000, 6'h01, 0, 0, 1, "R5"); // 4 vs 5
    step(1, 0, 32'h0000_FF01, 6'h3F, 0, 0, 1, "R5");
    step(1, 1, 32'h0000_0300, 6'h3F, 0, 0, 1, "R5"); // 255 vs 255
    step(1, 0, 32'h0000_0001, 6'h00, 0, 0, 1, "R5");
    step(1, 1, 32'h0000_0100, 6'h00, 0, 0, 1, "R5"); // 1 vs 0
    step(1, 1, 32'h0000_0000, 6'h00, 0, 0, 1, "R5"); // 0 vs 0
  endtask

  task automatic t_ignore; // R6
    step(1, 0, 32'hFFFF_01F9, 6'h00, 0, 0, 0, "R6");
    step(1, 1, 32'hFFFF_FCFF, 6'h00, 0, 0, 0, "R6");
    check("R6", "junk bits leave pending low", irq_pending, 1'b0);
    step(1, 1, 32'h0000_0100, 6'h00, 0, 0, 0, "R6");
    step(1, 1, 32'hA5A5_00FF, 6'h00, 0, 0, 0, "R6");
  endtask

  task automatic t_hw_lines; // R7
    step(1, 0, 32'h0000_FC01, 6'h00, 0, 0, 0, "R7");
    step(1, 1, 32'h0000_FC00, 6'h00, 0, 0, 0, "R7");
    check("R7", "written hw bits ignored", irq_pending, 1'b0);
    step(0, 0, 32'h0, 6'h01, 0, 0, 0, "R7");
    step(0, 0, 32'h0, 6'h00, 0, 0, 0, "R7");
    step(1, 0, 32'h0000_0301, 6'h00, 0, 0, 0, "R7");
    step(1, 1, 32'h0000_0200, 6'h00, 0, 0, 0, "R7");
    step(0, 0, 32'h0, 6'h00, 0, 0, 0, "R7"); // sw bit holds
  endtask

  task automatic t_latency; // R9
    step(0, 0, 32'h0, 6'h00, 0, 0, 0, "R9");
    check("R9", "take high with both qualifiers", take_irq, 1'b1);
    dbg_mode = 1'b1;
    #1;
    check("R9", "enabled drops at once", irq_enabled, 1'b0);
    check("R9", "take still high before edge", take_irq, 1'b1);
    @(negedge clk);
    check("R9", "take low one edge later", take_irq, 1'b0);
    step(0, 0, 32'h0, 6'h00, 0, 0, 0, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_bits();
    t_debug();
    t_exempt();
    t_compat();
    t_extvec();
    t_ignore();
    t_hw_lines();
    t_latency();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule